// File: doc/BRIEF.md
# Closed-Loop Bulk Erase Sequencer

This block is a host-side controller that erases a reprogrammable byte-wide memory of 2^ADDR_W locations (256K by default). Each cycle of its loop first raises the programming-voltage enable. It then issues the two-write erase command, waits out an erase interval and walks the array one byte at a time. Each byte gets an erase-verify command, a settling wait and a read-back. Any byte that does not read back as all ones triggers another bulk erase. Verification then picks up again at that same byte, so the bytes already proven erased are not read again.

The memory's command interface is presented as two streams. The command stream is valid/ready and carries a read/write flag, an address and a data byte. The response stream is valid/ready and returns the read-back byte. A command is transferred on a clock edge where `cmd_valid` and `cmd_ready` are both high. While `cmd_valid` is high and `cmd_ready` is low, the payload holds still. The sequencer raises `rsp_ready` only while it waits for the byte it asked for, and it accepts that byte on an edge where `rsp_valid` and `rsp_ready` are both high. The environment may stall either stream for any number of cycles.

Control stays plain: a one-cycle `start` request, a `busy` level, and `done`/`erase_err` levels that hold until the next accepted start. The erase and settling waits are tick-count parameters, so a bench can shorten them.

Top module: `erase_sequencer`

## Requirements
- R1: After reset, `busy`, `done`, `erase_err`, `vpp_en` and `cmd_valid` are all 0.
- R2: A start while idle raises `busy` and `vpp_en`. The first command is a write (cmd_rd=0) of data 20H. No data-bearing write precedes it.
- R3: Every erase pulse is exactly two consecutive 20H writes. The next command is sent no sooner than ERASE_TICKS cycles after the second write is transferred.
- R4: A byte is checked with a write of A0H carrying the byte's address. A read (cmd_rd=1) of the same address follows, no sooner than VERIFY_TICKS cycles after that write. After the first pulse, checking starts at address 0, and after each pass the address rises by one.
- R5: A byte passes only when the response byte is FFH. Any other value, including FEH or 7FH, starts another erase pulse.
- R6: After a re-erase, the first address checked is the address that failed.
- R7: The sequencer issues at most MAX_PULSES erase pulses. A failed check after pulse number MAX_PULSES ends the run with `erase_err`=1.
- R8: When the last address passes, the run ends with `done`=1 and `erase_err`=0, even if this happens on the final allowed pulse.
- R9: Every run ends with a write of data 00H. After that write `vpp_en` falls and `busy` falls. `vpp_en` is 1 whenever `cmd_valid` is 1.
- R10: While `cmd_valid` is 1 and `cmd_ready` is 0, the command payload holds still. A response is taken only when `rsp_ready` is 1, and the results do not change under stalls on either stream.
- R11: A start pulse while `busy` is 1 has no effect on the run in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to begin an erase run (taken when idle) |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run finished; held until next start |
| erase_err | output | 1 | Last run exhausted the pulse budget; held until next start |
| vpp_en | output | 1 | Programming-voltage enable |
| cmd_valid | output | 1 | Command stream valid |
| cmd_ready | input | 1 | Command stream ready |
| cmd_rd | output | 1 | 1 = read request, 0 = command write |
| cmd_addr | output | ADDR_W | Command address |
| cmd_data | output | 8 | Command write data |
| rsp_valid | input | 1 | Read-back stream valid |
| rsp_ready | output | 1 | Read-back stream ready |
| rsp_data | input | 8 | Read-back byte |

## Verification
The hardest case to reach from the ports is the resume path: a byte in the middle of the array fails after some pulse, and verification must restart there rather than at zero. A second, later byte must then fail on a later pulse as well. The bench uses a memory model in which each byte needs its own number of pulses before it reads FFH. By choosing those counts, it steers the sequencer through several resumes, a pass on exactly the last allowed pulse, and budget exhaustion. It logs the first address read after each pulse and the total number of reads.

// File: rtl/erase_seq_pkg.sv
package erase_seq_pkg;

  localparam logic [7:0] OP_ERASE  = 8'h20;
  localparam logic [7:0] OP_VERIFY = 8'hA0;
  localparam logic [7:0] OP_READ   = 8'h00;
  localparam logic [7:0] BYTE_BLANK = 8'hFF;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ERASE_A,
    ST_ERASE_B,
    ST_ERASE_WAIT,
    ST_VFY_CMD,
    ST_VFY_WAIT,
    ST_VFY_READ,
    ST_VFY_RSP,
    ST_FINISH
  } seq_state_t;

endpackage

// File: rtl/erase_tick_timer.sv
module erase_tick_timer #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              remain <= '0;
    else if (load)           remain <= load_val;
    else if (remain != '0)   remain <= remain - 1'b1;
  end

  assign expired = (remain == '0);

  // R3: once run out, the timer stays run out until reloaded
  a_r3_expired_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    expired && !load |=> expired);

endmodule

// File: rtl/erase_pulse_ctr.sv
module erase_pulse_ctr #(
  parameter int MAX_PULSES = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic inc,
  output logic at_limit
);

  localparam int CW = $clog2(MAX_PULSES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(MAX_PULSES);

  logic [CW-1:0] used;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      used <= '0;
    else if (clear)  used <= '0;
    else if (inc)    used <= used + 1'b1;
  end

  assign at_limit = (used == LIMIT);

  // R7: the number of pulses never passes the budget
  a_r7_within_budget: assert property (@(posedge clk) disable iff (!rst_n)
    used <= LIMIT);

endmodule

// File: rtl/erase_addr_track.sv
module erase_addr_track #(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              advance,
  output logic [ADDR_W-1:0] addr,
  output logic              is_last
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        addr <= '0;
    else if (clear)    addr <= '0;
    else if (advance)  addr <= addr + 1'b1;
  end

  assign is_last = (addr == {ADDR_W{1'b1}});

  // R6: within a run the checked address never moves backwards
  a_r6_no_backstep: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> addr >= $past(addr));

endmodule

// File: rtl/erase_sequencer.sv
module erase_sequencer
  import erase_seq_pkg::*;
#(
  parameter int ADDR_W       = 18,
  parameter int ERASE_TICKS  = 10_000_000,
  parameter int VERIFY_TICKS = 600,
  parameter int MAX_PULSES   = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              erase_err,
  output logic              vpp_en,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic              cmd_rd,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [7:0]        cmd_data,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [7:0]        rsp_data
);

  localparam int LONGEST = (ERASE_TICKS > VERIFY_TICKS) ? ERASE_TICKS : VERIFY_TICKS;
  localparam int TW = $clog2(LONGEST + 1);
  localparam logic [TW-1:0] ERASE_LD  = TW'(ERASE_TICKS - 1);
  localparam logic [TW-1:0] VERIFY_LD = TW'(VERIFY_TICKS - 1);

  seq_state_t state, state_nx;

  logic              cmd_fire, rsp_fire;
  logic              tmr_load, tmr_expired;
  logic [TW-1:0]     tmr_val;
  logic              ctr_clear, ctr_inc, ctr_at_limit;
  logic              adr_clear, adr_advance, adr_last;
  logic [ADDR_W-1:0] cur_addr;
  logic              fail_pend, fail_pend_nx;
  logic              start_take, finish_take;

  assign cmd_fire    = cmd_valid && cmd_ready;
  assign rsp_fire    = rsp_valid && rsp_ready;
  assign start_take  = (state == ST_IDLE) && start;
  assign finish_take = (state == ST_FINISH) && cmd_fire;

  erase_tick_timer #(.W(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  erase_pulse_ctr #(.MAX_PULSES(MAX_PULSES)) u_pulses (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (ctr_clear),
    .inc      (ctr_inc),
    .at_limit (ctr_at_limit)
  );

  erase_addr_track #(.ADDR_W(ADDR_W)) u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (adr_clear),
    .advance (adr_advance),
    .addr    (cur_addr),
    .is_last (adr_last)
  );

  // Next-state and control decode
  always_comb begin
    state_nx     = state;
    tmr_load     = 1'b0;
    tmr_val      = ERASE_LD;
    ctr_clear    = 1'b0;
    ctr_inc      = 1'b0;
    adr_clear    = 1'b0;
    adr_advance  = 1'b0;
    fail_pend_nx = fail_pend;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          ctr_clear    = 1'b1;
          adr_clear    = 1'b1;
          fail_pend_nx = 1'b0;
          state_nx     = ST_ERASE_A;
        end
      end
      ST_ERASE_A: if (cmd_fire) state_nx = ST_ERASE_B;
      ST_ERASE_B: begin
        if (cmd_fire) begin
          ctr_inc  = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = ERASE_LD;
          state_nx = ST_ERASE_WAIT;
        end
      end
      ST_ERASE_WAIT: if (tmr_expired) state_nx = ST_VFY_CMD;
      ST_VFY_CMD: begin
        if (cmd_fire) begin
          tmr_load = 1'b1;
          tmr_val  = VERIFY_LD;
          state_nx = ST_VFY_WAIT;
        end
      end
      ST_VFY_WAIT: if (tmr_expired) state_nx = ST_VFY_READ;
      ST_VFY_READ: if (cmd_fire) state_nx = ST_VFY_RSP;
      ST_VFY_RSP: begin
        if (rsp_fire) begin
          if (rsp_data == BYTE_BLANK) begin
            if (adr_last) begin
              state_nx = ST_FINISH;
            end else begin
              adr_advance = 1'b1;
              state_nx    = ST_VFY_CMD;
            end
          end else if (ctr_at_limit) begin
            fail_pend_nx = 1'b1;
            state_nx     = ST_FINISH;
          end else begin
            state_nx = ST_ERASE_A;
          end
        end
      end
      ST_FINISH: if (cmd_fire) state_nx = ST_IDLE;
      default: state_nx = ST_IDLE;
    endcase
  end

  // Command payload decode
  always_comb begin
    cmd_valid = 1'b0;
    cmd_rd    = 1'b0;
    cmd_addr  = '0;
    cmd_data  = OP_READ;
    unique case (state)
      ST_ERASE_A, ST_ERASE_B: begin
        cmd_valid = 1'b1;
        cmd_data  = OP_ERASE;
      end
      ST_VFY_CMD: begin
        cmd_valid = 1'b1;
        cmd_addr  = cur_addr;
        cmd_data  = OP_VERIFY;
      end
      ST_VFY_READ: begin
        cmd_valid = 1'b1;
        cmd_rd    = 1'b1;
        cmd_addr  = cur_addr;
      end
      ST_FINISH: begin
        cmd_valid = 1'b1;
        cmd_data  = OP_READ;
      end
      default: ;
    endcase
  end

  assign rsp_ready = (state == ST_VFY_RSP);
  assign busy      = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      fail_pend <= 1'b0;
      vpp_en    <= 1'b0;
      done      <= 1'b0;
      erase_err <= 1'b0;
    end else begin
      state     <= state_nx;
      fail_pend <= fail_pend_nx;
      if (start_take) begin
        vpp_en    <= 1'b1;
        done      <= 1'b0;
        erase_err <= 1'b0;
      end else if (finish_take) begin
        vpp_en    <= 1'b0;
        done      <= 1'b1;
        erase_err <= fail_pend;
      end
    end
  end

  // R10: a stalled command keeps its payload
  a_r10_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_rd) && $stable(cmd_addr) && $stable(cmd_data));

  // R9: commands only go out with the programming voltage on
  a_r9_vpp_with_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> vpp_en);

  // R3 / R4: the bus is silent during both waits
  a_r3_quiet_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ERASE_WAIT || state == ST_VFY_WAIT) |-> !cmd_valid);

  // R8: done is only reported once idle
  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R7: an error is always reported together with done
  a_r7_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    erase_err |-> done);

  // R4: the address tracker never advances past the top
  a_r4_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    adr_advance |-> !adr_last);

endmodule

// File: tb/test_erase_sequencer.sv
module test_erase_sequencer;

  localparam int AW  = 4;
  localparam int NB  = 1 << AW;
  localparam int ET  = 20;
  localparam int VT  = 5;
  localparam int MP  = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic busy, done, erase_err, vpp_en;
  logic cmd_valid, cmd_ready, cmd_rd, rsp_valid, rsp_ready;
  logic [AW-1:0] cmd_addr;
  logic [7:0] cmd_data, rsp_data;

  always #5 clk = ~clk;

  erase_sequencer #(.ADDR_W(AW), .ERASE_TICKS(ET), .VERIFY_TICKS(VT), .MAX_PULSES(MP)) i_erase_sequencer (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .erase_err(erase_err), .vpp_en(vpp_en), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_rd(cmd_rd), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data)
  );

  int total = 0;
  int bad = 0;

  // memory model controls, set by tasks
  int  need [NB];
  logic [7:0] fail_val = 8'h7F;
  bit  stall = 1'b0;
  bit  model_clr = 1'b0;

  // memory model observations
  int cyc = 0, pulses = 0, reads = 0, cmds = 0, fins = 0, perr = 0;
  int first_rd [8];
  bit half = 0, armed = 0, new_pulse = 0, hold = 0, after_fin = 0;
  int t_erase = 0, t_vfy = 0, rsp_wait = 0;
  bit rsp_pend = 0;
  logic [AW-1:0] vaddr = '0;
  logic [AW+9:0] snap = '0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    cmd_ready <= stall ? (cyc % 3 == 0) : 1'b1;
    if (model_clr) begin
      pulses <= 0; reads <= 0; cmds <= 0; fins <= 0; perr <= 0;
      half <= 0; armed <= 0; new_pulse <= 0; hold <= 0; after_fin <= 0;
      rsp_pend <= 0; rsp_valid <= 1'b0;
      for (int i = 0; i < 8; i++) first_rd[i] <= -1;
    end else begin
      if (hold && (!cmd_valid || snap != {cmd_rd, cmd_addr, cmd_data})) perr <= perr + 1;
      hold <= cmd_valid && !cmd_ready;
      snap <= {cmd_rd, cmd_addr, cmd_data};
      if (cmd_valid && cmd_ready) begin
        cmds <= cmds + 1;
        if (!vpp_en || after_fin) perr <= perr + 1;
        if (cmds == 0 && (cmd_rd || cmd_data != 8'h20)) perr <= perr + 1;
        if (cmd_rd) begin
          if (!armed || cmd_addr != vaddr || cyc - t_vfy < VT) perr <= perr + 1;
          armed <= 0;
          reads <= reads + 1;
          if (new_pulse) begin
            first_rd[pulses] <= int'(cmd_addr);
            new_pulse <= 0;
          end
          rsp_data <= (pulses >= need[cmd_addr]) ? 8'hFF : fail_val;
          rsp_pend <= 1;
          rsp_wait <= stall ? 2 : 0;
        end else begin
          if (half && cmd_data != 8'h20) perr <= perr + 1;
          case (cmd_data)
            8'h20: begin
              if (half) begin
                pulses <= pulses + 1;
                t_erase <= cyc;
                new_pulse <= 1;
              end
              half <= ~half;
            end
            8'hA0: begin
              if (new_pulse && cyc - t_erase < ET) perr <= perr + 1;
              vaddr <= cmd_addr;
              armed <= 1;
              t_vfy <= cyc;
            end
            8'h00: begin
              fins <= fins + 1;
              after_fin <= 1;
            end
            default: perr <= perr + 1;
          endcase
        end
      end
      if (rsp_pend && !rsp_valid) begin
        if (rsp_wait == 0) begin
          rsp_valid <= 1'b1;
          rsp_pend <= 0;
        end else begin
          rsp_wait <= rsp_wait - 1;
        end
      end
      if (rsp_valid && rsp_ready) rsp_valid <= 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setup(input int base, input logic [7:0] fv, input bit st);
    for (int i = 0; i < NB; i++) need[i] = base;
    fail_val = fv;
    stall = st;
    @(negedge clk);
    model_clr = 1'b1;
    @(negedge clk);
    model_clr = 1'b0;
  endtask

  task automatic run(input bit poke_restart);
    int n = 0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy && vpp_en, "R2 busy/vpp after start", {30'd0, busy, vpp_en}, 3);
    if (poke_restart) begin
      repeat (40) @(negedge clk);
      start = 1'b1;           // R11: must be ignored
      @(negedge clk);
      start = 1'b0;
    end
    while (!done && n < 20000) begin
      @(negedge clk);
      n++;
    end
    chk(done, "R8 run finished (watchdog)", int'(done), 1);
    chk(!busy && !vpp_en && fins == 1, "R9 ends with 00H, vpp off",
        fins + 10 * int'(vpp_en) + 100 * int'(busy), 1);
    chk(perr == 0, "R3/R4/R10 command protocol", perr, 0);
  endtask

  task automatic t_reset;
    chk(!busy && !done && !erase_err && !vpp_en && !cmd_valid, "R1 reset state",
        {27'd0, busy, done, erase_err, vpp_en, cmd_valid}, 0);
  endtask

  task automatic t_single_pulse;
    setup(1, 8'h7F, 0);
    run(0);
    chk(pulses == 1, "R2 one pulse", pulses, 1);
    chk(reads == NB, "R4 every byte read", reads, NB);
    chk(first_rd[1] == 0, "R4 starts at 0", first_rd[1], 0);
    chk(!erase_err, "R8 no error", int'(erase_err), 0);
  endtask

  task automatic t_resume(input bit st, input bit poke);
    setup(1, 8'h7F, st);
    need[5] = 2;
    need[9] = 3;
    run(poke);
    chk(pulses == 3, st ? "R10 pulses under stall" : (poke ? "R11 pulses" : "R6 pulses"), pulses, 3);
    chk(reads == 18, "R6 reads with resume", reads, 18);
    chk(first_rd[2] == 5, "R6 resume at 5", first_rd[2], 5);
    chk(first_rd[3] == 9, "R6 resume at 9", first_rd[3], 9);
    chk(!erase_err, "R8 no error", int'(erase_err), 0);
  endtask

  task automatic t_near_blank;
    setup(1, 8'hFE, 0);
    need[0] = 2;
    run(0);
    chk(pulses == 2, "R5 FEH fails", pulses, 2);
    chk(reads == NB + 1, "R5 reads", reads, NB + 1);
  endtask

  task automatic t_budget_out;
    setup(1, 8'h7F, 0);
    need[3] = 99;
    run(0);
    chk(pulses == MP, "R7 pulse budget", pulses, MP);
    chk(reads == 8, "R7 reads", reads, 8);
    chk(erase_err && done, "R7 error flagged", int'(erase_err), 1);
  endtask

  task automatic t_last_chance;
    setup(1, 8'h7F, 0);
    need[NB-1] = MP;
    run(0);
    chk(pulses == MP, "R8 pass on last pulse", pulses, MP);
    chk(reads == NB + MP - 1, "R8 reads", reads, NB + MP - 1);
    chk(!erase_err && done, "R8 no error at limit", int'(erase_err), 0);
  endtask

  initial begin
    cmd_ready = 1'b1;
    rsp_valid = 1'b0;
    rsp_data  = 8'h00;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_single_pulse;
    t_resume(0, 0);
    t_near_blank;
    t_budget_out;
    t_last_chance;
    t_resume(1, 0);
    t_resume(0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1500000;
    bad++;
    total++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule